// File: doc/BRIEF.md
# Effective Address Generation Unit

This block turns an addressing-mode code and register indices into data-memory effective addresses (EAs) for move and accumulator class operations. It holds a file of sixteen 16-bit working registers. Each request resolves a source operand and a destination operand. Each side has its own mode and base register. Both sides share one offset-register index and one signed literal.

The source side is resolved first. The destination side then sees the register file as it stands after the source update. Modes that modify their base register report the new value on a per-side write-back port and commit it to the register file at the same clock edge. A separate write port lets the datapath load registers. An error flag marks a word access whose effective address is odd.

Results are registered and appear one cycle after the request strobe.

Top module: `eagu_top`

## Requirements
- R1: After reset all registers read 0 and every output is 0.
- R2: Mode code 0 (register direct) produces no EA (`*_ea_vld_o`=0) and no write-back; on the source side `src_opnd_o` carries the base register contents, otherwise `src_opnd_o` is 0.
- R3: Mode code 1 (indirect) gives EA = Wn, with no write-back.
- R4: Mode codes 2 (post-increment) and 3 (post-decrement) give EA = old Wn. Wn is written back as old ± step, where step is 1 when `byte_i`=1 and 2 when `byte_i`=0.
- R5: Mode codes 4 (pre-increment) and 5 (pre-decrement) compute Wn ± step. That value is both the EA and the write-back value.
- R6: Mode code 6 (indexed) gives EA = Wn + W[`wb_idx_i`], with no write-back. The single `wb_idx_i` serves both sides.
- R7: Mode code 7 (literal offset) gives EA = Wn + the sign-extended `lit_i`, with no write-back.
- R8: All EA and write-back arithmetic wraps modulo 2^16.
- R9: `err_o` is 1 exactly when `byte_i`=0 and a side with a valid EA has EA bit 0 set.
- R10: The destination side reads registers after the source write-back is applied. When both sides write the same register, the destination value is what remains.
- R11: Outputs change one cycle after `req_i`. In a cycle after no request, `vld_o`, `err_o` and both write-back enables are 0.
- R12: `wr_en_i` loads `wr_data_i` into register `wr_idx_i`. A same-cycle write-back to the same register wins over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Resolve request strobe |
| src_mode_i | input | 3 | Source addressing mode code |
| src_wn_i | input | 4 | Source base register index |
| dst_mode_i | input | 3 | Destination addressing mode code |
| dst_wn_i | input | 4 | Destination base register index |
| wb_idx_i | input | 4 | Shared offset register index |
| lit_i | input | 10 | Shared signed literal offset |
| byte_i | input | 1 | 1 = byte access, 0 = word access |
| wr_en_i | input | 1 | External register write enable |
| wr_idx_i | input | 4 | External write register index |
| wr_data_i | input | 16 | External write data |
| vld_o | output | 1 | Result valid |
| src_ea_o | output | 16 | Source EA |
| src_ea_vld_o | output | 1 | Source EA present |
| src_opnd_o | output | 16 | Source register operand (direct mode) |
| dst_ea_o | output | 16 | Destination EA |
| dst_ea_vld_o | output | 1 | Destination EA present |
| err_o | output | 1 | Misaligned word access |
| src_wb_en_o | output | 1 | Source write-back enable |
| src_wb_idx_o | output | 4 | Source write-back register |
| src_wb_data_o | output | 16 | Source write-back value |
| dst_wb_en_o | output | 1 | Destination write-back enable |
| dst_wb_idx_o | output | 4 | Destination write-back register |
| dst_wb_data_o | output | 16 | Destination write-back value |

## Verification
Two things can fall in the same cycle. The source write-back can update a register that the destination side reads, either as its base or as the shared offset. An external load can also target a register being written back. Directed pairs put both sides on one register in modifying modes, and aim a load at a post-modified register. Random requests draw register indices from a narrow range so that these overlaps occur often. The register file is then read back through direct mode and compared with a sequential bench model in which the source is applied before the destination.

// File: rtl/eagu_pkg.sv
package eagu_pkg;
  typedef enum logic [2:0] {
    AM_DIRECT   = 3'd0,
    AM_IND      = 3'd1,
    AM_POST_INC = 3'd2,
    AM_POST_DEC = 3'd3,
    AM_PRE_INC  = 3'd4,
    AM_PRE_DEC  = 3'd5,
    AM_INDEXED  = 3'd6,
    AM_LIT      = 3'd7
  } amode_e;
endpackage

// File: rtl/eagu_regfile.sv
module eagu_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [IW-1:0]            wr_idx_i,
  input  logic [DW-1:0]            wr_data_i,
  input  logic                     a_en_i,
  input  logic [IW-1:0]            a_idx_i,
  input  logic [DW-1:0]            a_data_i,
  input  logic                     b_en_i,
  input  logic [IW-1:0]            b_idx_i,
  input  logic [DW-1:0]            b_data_i,
  output logic [NREG-1:0][DW-1:0]  rf_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    // priority: destination write-back, source write-back, external load
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 rf_o[g] <= '0;
      else if (b_en_i  && b_idx_i  == IW'(g))      rf_o[g] <= b_data_i;
      else if (a_en_i  && a_idx_i  == IW'(g))      rf_o[g] <= a_data_i;
      else if (wr_en_i && wr_idx_i == IW'(g))      rf_o[g] <= wr_data_i;
    end
  end
endmodule

// File: rtl/eagu_side.sv
module eagu_side
  import eagu_pkg::*;
#(
  parameter int DW = 16
) (
  input  amode_e         mode_i,
  input  logic [DW-1:0]  wn_i,
  input  logic [DW-1:0]  ofs_i,
  input  logic [DW-1:0]  lit_i,
  input  logic           byte_i,
  output logic [DW-1:0]  ea_o,
  output logic           ea_vld_o,
  output logic           wb_en_o,
  output logic [DW-1:0]  wb_data_o,
  output logic           mis_o
);
  logic [DW-1:0] step, inc, dec;

  always_comb begin
    step      = byte_i ? DW'(1) : DW'(2);
    inc       = wn_i + step;
    dec       = wn_i - step;
    ea_o      = '0;
    ea_vld_o  = 1'b1;
    wb_en_o   = 1'b0;
    wb_data_o = '0;
    unique case (mode_i)
      AM_DIRECT:   ea_vld_o = 1'b0;
      AM_IND:      ea_o = wn_i;
      AM_POST_INC: begin ea_o = wn_i; wb_en_o = 1'b1; wb_data_o = inc; end
      AM_POST_DEC: begin ea_o = wn_i; wb_en_o = 1'b1; wb_data_o = dec; end
      AM_PRE_INC:  begin ea_o = inc;  wb_en_o = 1'b1; wb_data_o = inc; end
      AM_PRE_DEC:  begin ea_o = dec;  wb_en_o = 1'b1; wb_data_o = dec; end
      AM_INDEXED:  ea_o = wn_i + ofs_i;
      AM_LIT:      ea_o = wn_i + lit_i;
      default:     ea_vld_o = 1'b0;
    endcase
    mis_o = ea_vld_o & ~byte_i & ea_o[0];
  end
endmodule

// File: rtl/eagu_top.sv
module eagu_top
  import eagu_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int DW    = 16,
  parameter int LIT_W = 10,
  localparam int IW   = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [2:0]       src_mode_i,
  input  logic [IW-1:0]    src_wn_i,
  input  logic [2:0]       dst_mode_i,
  input  logic [IW-1:0]    dst_wn_i,
  input  logic [IW-1:0]    wb_idx_i,
  input  logic [LIT_W-1:0] lit_i,
  input  logic             byte_i,
  input  logic             wr_en_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic             vld_o,
  output logic [DW-1:0]    src_ea_o,
  output logic             src_ea_vld_o,
  output logic [DW-1:0]    src_opnd_o,
  output logic [DW-1:0]    dst_ea_o,
  output logic             dst_ea_vld_o,
  output logic             err_o,
  output logic             src_wb_en_o,
  output logic [IW-1:0]    src_wb_idx_o,
  output logic [DW-1:0]    src_wb_data_o,
  output logic             dst_wb_en_o,
  output logic [IW-1:0]    dst_wb_idx_o,
  output logic [DW-1:0]    dst_wb_data_o
);
  logic [NREG-1:0][DW-1:0] rf;
  logic [DW-1:0] lit_x;
  logic [DW-1:0] s_wn, s_ofs, s_ea, s_wbd;
  logic [DW-1:0] d_wn, d_ofs, d_ea, d_wbd;
  logic s_ev, s_wbe, s_mis, d_ev, d_wbe, d_mis;
  logic s_we, d_we;
  amode_e s_mode, d_mode;

  assign lit_x  = {{(DW-LIT_W){lit_i[LIT_W-1]}}, lit_i};
  assign s_mode = amode_e'(src_mode_i);
  assign d_mode = amode_e'(dst_mode_i);
  assign s_wn   = rf[src_wn_i];
  assign s_ofs  = rf[wb_idx_i];

  eagu_side #(.DW(DW)) i_src (
    .mode_i(s_mode), .wn_i(s_wn), .ofs_i(s_ofs), .lit_i(lit_x), .byte_i(byte_i),
    .ea_o(s_ea), .ea_vld_o(s_ev), .wb_en_o(s_wbe), .wb_data_o(s_wbd), .mis_o(s_mis)
  );

  // destination sees the register file after the source update
  assign d_wn  = (s_wbe && src_wn_i == dst_wn_i) ? s_wbd : rf[dst_wn_i];
  assign d_ofs = (s_wbe && src_wn_i == wb_idx_i) ? s_wbd : rf[wb_idx_i];

  eagu_side #(.DW(DW)) i_dst (
    .mode_i(d_mode), .wn_i(d_wn), .ofs_i(d_ofs), .lit_i(lit_x), .byte_i(byte_i),
    .ea_o(d_ea), .ea_vld_o(d_ev), .wb_en_o(d_wbe), .wb_data_o(d_wbd), .mis_o(d_mis)
  );

  assign s_we = req_i & s_wbe;
  assign d_we = req_i & d_wbe;

  eagu_regfile #(.NREG(NREG), .DW(DW)) i_rf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .a_en_i(s_we), .a_idx_i(src_wn_i), .a_data_i(s_wbd),
    .b_en_i(d_we), .b_idx_i(dst_wn_i), .b_data_i(d_wbd),
    .rf_o(rf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o         <= 1'b0;
      src_ea_o      <= '0;
      src_ea_vld_o  <= 1'b0;
      src_opnd_o    <= '0;
      dst_ea_o      <= '0;
      dst_ea_vld_o  <= 1'b0;
      err_o         <= 1'b0;
      src_wb_en_o   <= 1'b0;
      src_wb_idx_o  <= '0;
      src_wb_data_o <= '0;
      dst_wb_en_o   <= 1'b0;
      dst_wb_idx_o  <= '0;
      dst_wb_data_o <= '0;
    end else begin
      vld_o         <= req_i;
      src_ea_o      <= req_i ? s_ea : '0;
      src_ea_vld_o  <= req_i & s_ev;
      src_opnd_o    <= (req_i && s_mode == AM_DIRECT) ? s_wn : '0;
      dst_ea_o      <= req_i ? d_ea : '0;
      dst_ea_vld_o  <= req_i & d_ev;
      err_o         <= req_i & (s_mis | d_mis);
      src_wb_en_o   <= s_we;
      src_wb_idx_o  <= s_we ? src_wn_i : '0;
      src_wb_data_o <= s_we ? s_wbd : '0;
      dst_wb_en_o   <= d_we;
      dst_wb_idx_o  <= d_we ? dst_wn_i : '0;
      dst_wb_data_o <= d_we ? d_wbd : '0;
    end
  end
endmodule

// File: rtl/eagu_checker.sv
module eagu_checker #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          byte_i,
  input logic          vld_o,
  input logic [DW-1:0] src_ea_o,
  input logic          src_ea_vld_o,
  input logic          dst_ea_vld_o,
  input logic          err_o,
  input logic          src_wb_en_o,
  input logic [DW-1:0] src_wb_data_o,
  input logic          dst_wb_en_o
);
  logic [DW-1:0] diff;
  assign diff = src_wb_data_o - src_ea_o;

  assert_vld_follows_req_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> vld_o == $past(req_i));
  assert_no_wb_when_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> (!src_wb_en_o && !dst_wb_en_o && !err_o));
  assert_err_needs_ea_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_ea_vld_o && !dst_ea_vld_o) |-> !err_o);
  assert_err_word_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 err_o |-> !$past(byte_i));
  assert_modify_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_wb_en_o |-> (diff == DW'(0) || diff == DW'(1) || diff == DW'(2) ||
                     diff == {DW{1'b1}} || diff == ({DW{1'b1}} - DW'(1))));
endmodule

bind eagu_top eagu_checker #(.DW(DW)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .byte_i(byte_i), .vld_o(vld_o),
  .src_ea_o(src_ea_o), .src_ea_vld_o(src_ea_vld_o), .dst_ea_vld_o(dst_ea_vld_o),
  .err_o(err_o), .src_wb_en_o(src_wb_en_o), .src_wb_data_o(src_wb_data_o),
  .dst_wb_en_o(dst_wb_en_o)
);

// File: tb/test_eagu_top.sv
module test_eagu_top;
  localparam int CLK_PERIOD = 10;
  localparam int LIT_W = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 0, byt = 0, we = 0;
  logic [2:0] sm = 0, dm = 0;
  logic [3:0] sw = 0, dw = 0, wbi = 0, widx = 0;
  logic [LIT_W-1:0] lit = 0;
  logic [15:0] wdat = 0;
  logic vld, sev, dev, err, swe, dwe;
  logic [15:0] sea, sop, dea, swd, dwd;
  logic [3:0] swi, dwi;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] m [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  eagu_top i_eagu_top (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .src_mode_i(sm), .src_wn_i(sw),
    .dst_mode_i(dm), .dst_wn_i(dw), .wb_idx_i(wbi), .lit_i(lit), .byte_i(byt),
    .wr_en_i(we), .wr_idx_i(widx), .wr_data_i(wdat), .vld_o(vld),
    .src_ea_o(sea), .src_ea_vld_o(sev), .src_opnd_o(sop), .dst_ea_o(dea),
    .dst_ea_vld_o(dev), .err_o(err), .src_wb_en_o(swe), .src_wb_idx_o(swi),
    .src_wb_data_o(swd), .dst_wb_en_o(dwe), .dst_wb_idx_o(dwi), .dst_wb_data_o(dwd)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] md);
    case (md)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2, 3'd3: return "R4";
      3'd4, 3'd5: return "R5";
      3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  // bench model of one side
  function automatic void side(input logic [2:0] md, input logic [15:0] base,
      input logic [15:0] ofs, input logic [LIT_W-1:0] l, input logic b,
      output logic [15:0] ea, output logic ev, output logic wen, output logic [15:0] wv);
    int unsigned st = b ? 1 : 2;
    logic [15:0] lx = 16'($signed(l));
    ev = (md != 3'd0); wen = (md >= 3'd2 && md <= 3'd5); ea = 0; wv = 0;
    if (md == 3'd2 || md == 3'd4) wv = 16'(base + st);
    if (md == 3'd3 || md == 3'd5) wv = 16'(base - st);
    if (md == 3'd1 || md == 3'd2 || md == 3'd3) ea = base;
    if (md == 3'd4 || md == 3'd5) ea = wv;
    if (md == 3'd6) ea = 16'(base + ofs);
    if (md == 3'd7) ea = 16'(base + lx);
  endfunction

  task automatic run(input logic [2:0] s_m, input logic [3:0] s_w,
                     input logic [2:0] d_m, input logic [3:0] d_w,
                     input logic [3:0] o_i, input logic [LIT_W-1:0] l,
                     input logic b, input logic w_e, input logic [3:0] w_i,
                     input logic [15:0] w_d, input string tag);
    logic [15:0] e_sea, e_swd, e_dea, e_dwd, dbase, dofs;
    logic e_sev, e_swe, e_dev, e_dwe, e_err;
    logic [15:0] v [16];
    side(s_m, m[s_w], m[o_i], l, b, e_sea, e_sev, e_swe, e_swd);
    v = m;
    if (e_swe) v[s_w] = e_swd;
    dbase = v[d_w]; dofs = v[o_i];
    side(d_m, dbase, dofs, l, b, e_dea, e_dev, e_dwe, e_dwd);
    e_err = !b && ((e_sev && e_sea[0]) || (e_dev && e_dea[0]));
    sm = s_m; sw = s_w; dm = d_m; dw = d_w; wbi = o_i; lit = l; byt = b;
    we = w_e; widx = w_i; wdat = w_d; req = 1;
    @(posedge clk); @(negedge clk);
    req = 0; we = 0;
    chk(vld === 1'b1, "R11", {tag, " vld"}, 16'(vld), 16'd1);
    chk(sev === e_sev, tag, "src ea_vld", 16'(sev), 16'(e_sev));
    chk(sea === e_sea, tag, "src ea", sea, e_sea);
    chk(swe === e_swe, tag, "src wb_en", 16'(swe), 16'(e_swe));
    if (e_swe) chk(swd === e_swd && swi === s_w, tag, "src wb", swd, e_swd);
    chk(sop === (s_m == 3'd0 ? m[s_w] : 16'd0), "R2", {tag, " opnd"}, sop,
        s_m == 3'd0 ? m[s_w] : 16'd0);
    chk(dev === e_dev, tag, "dst ea_vld", 16'(dev), 16'(e_dev));
    chk(dea === e_dea, tag, "dst ea", dea, e_dea);
    chk(dwe === e_dwe, tag, "dst wb_en", 16'(dwe), 16'(e_dwe));
    if (e_dwe) chk(dwd === e_dwd && dwi === d_w, tag, "dst wb", dwd, e_dwd);
    chk(err === e_err, "R9", {tag, " err"}, 16'(err), 16'(e_err));
    if (w_e) m[w_i] = w_d;
    if (e_swe) m[s_w] = e_swd;
    if (e_dwe) m[d_w] = e_dwd;
  endtask

  task automatic rd(input logic [3:0] i, input string tag);
    logic [15:0] e = m[i];
    sm = 0; sw = i; dm = 0; dw = 0; req = 1;
    @(posedge clk); @(negedge clk);
    req = 0;
    chk(sop === e, tag, "register readback", sop, e);
  endtask

  initial begin
    void'($urandom(32'h5eed_0e4a));
    foreach (m[i]) m[i] = 0;
    repeat (3) @(negedge clk);
    chk(vld === 0 && sea === 0 && dea === 0 && err === 0 && swe === 0 && dwe === 0,
        "R1", "outputs in reset", {vld, err, swe, dwe}, 16'd0);
    rst_ni = 1;
    @(negedge clk);
    chk(vld === 0 && sop === 0, "R1", "outputs after reset", sop, 16'd0);
    rd(4'd5, "R1");
    // R12: load all registers
    for (int i = 0; i < 16; i++) begin
      we = 1; widx = 4'(i); wdat = 16'h1000 + 16'(i * 16'h0111);
      @(negedge clk); m[i] = wdat;
    end
    we = 0;
    @(negedge clk);
    chk(vld === 0 && swe === 0 && dwe === 0 && err === 0, "R11", "idle", 16'(vld), 16'd0);
    rd(4'd9, "R12");
    // R8 wrap cases
    m[1] = 16'hffff; we = 1; widx = 1; wdat = 16'hffff; @(negedge clk); we = 0;
    run(3'd2, 4'd1, 3'd1, 4'd0, 4'd0, 0, 1'b0, 0, 0, 0, "R8");
    chk(m[1] === 16'h0001, "R8", "post-inc wrap model", m[1], 16'h0001);
    rd(4'd1, "R8");
    m[2] = 0; we = 1; widx = 2; wdat = 0; @(negedge clk); we = 0;
    run(3'd5, 4'd2, 3'd0, 4'd0, 4'd0, 0, 1'b1, 0, 0, 0, "R5");
    rd(4'd2, "R8");
    run(3'd7, 4'd2, 3'd6, 4'd1, 4'd2, 10'h3ff, 1'b1, 0, 0, 0, "R7");
    // R9: odd word address vs byte
    run(3'd1, 4'd1, 3'd0, 4'd0, 4'd0, 0, 1'b0, 0, 0, 0, "R9");
    run(3'd1, 4'd1, 3'd0, 4'd0, 4'd0, 0, 1'b1, 0, 0, 0, "R9");
    // R10: both sides modify the same register
    run(3'd2, 4'd3, 3'd4, 4'd3, 4'd0, 0, 1'b0, 0, 0, 0, "R10");
    rd(4'd3, "R10");
    run(3'd3, 4'd4, 3'd6, 4'd5, 4'd4, 0, 1'b0, 0, 0, 0, "R10");
    // R6: shared offset on both sides
    run(3'd6, 4'd6, 3'd6, 4'd7, 4'd8, 0, 1'b0, 0, 0, 0, "R6");
    // R12: write-back beats external load on same register
    run(3'd2, 4'd6, 3'd1, 4'd0, 4'd0, 0, 1'b0, 1'b1, 4'd6, 16'hdead, "R12");
    rd(4'd6, "R12");
    run(3'd1, 4'd0, 3'd1, 4'd0, 4'd0, 0, 1'b0, 1'b1, 4'd10, 16'hbeef, "R12");
    rd(4'd10, "R12");
    // random, indices narrowed to force overlaps
    for (int k = 0; k < 400; k++) begin
      logic [2:0] a = 3'($urandom), c = 3'($urandom);
      run(a, 4'($urandom % 4), c, 4'($urandom % 4), 4'($urandom % 4),
          LIT_W'($urandom), 1'($urandom), 1'($urandom % 4 == 0),
          4'($urandom % 4), 16'($urandom), tag_of(a));
      if (k % 8 == 0) rd(4'($urandom % 4), "R10");
    end
    @(negedge clk);
    chk(vld === 0 && swe === 0 && dwe === 0, "R11", "idle after burst", 16'(vld), 16'd0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule